// File: doc/BRIEF.md
# Hashed Row Lookup Pipeline

This block is an exact-match search memory. Keys live in a RAM of 2^ROW_BITS rows, and each row holds SLOTS entries. An entry is a live flag, a key and a data word. A search key is reduced by an XOR fold to a row number. Only that one row is read, and all of its slots are compared with the key at the same time. A small fully associative overflow store holds entries that found no room in their own row. It is probed in the same stage as the row read, so a spilled entry costs no extra access.

Searches enter through a valid/ready stream and leave through a second valid/ready stream, one per cycle and in order. A transfer happens on a clock edge where valid and ready are both high. Back-pressure comes only from the result side. While a result is held (`r_valid` high and `r_ready` low), the whole pipeline freezes and `s_ready` is low. Otherwise `s_ready` is high. A plain write port loads or clears one row slot or one overflow entry per cycle. Software fills the rows in priority order, so the lowest matching slot is the answer.

Top module: `hash_row_lookup`

## Requirements
- R1: The row examined for key k is the XOR of the key's ROW_BITS-wide chunks, with the top chunk zero-padded. With the defaults this is k[5:0] ^ k[11:6] ^ {2'b00, k[15:12]}.
- R2: A live row entry whose key equals the search key gives `r_hit`=1 and `r_ovf`=0, with the slot number on `r_slot` and its data on `r_data`.
- R3: When several live slots of the row match, the lowest slot number wins.
- R4: The overflow store is searched for every key. A match there, with no row match, gives `r_hit`=1 and `r_ovf`=1, with the overflow entry number on `r_slot` and its data on `r_data`. The lowest matching entry wins.
- R5: When both the row and the overflow store match, the row result is returned.
- R6: A search that matches nothing returns `r_hit`=0, `r_ovf`=0, `r_slot`=0 and `r_data`=0.
- R7: A key accepted at clock edge k shows on the result outputs right after edge k+3. Back-to-back keys give back-to-back results in acceptance order.
- R8: While `r_valid`=1 and `r_ready`=0, all result outputs hold and `s_ready`=0. Otherwise `s_ready`=1.
- R9: With no back-pressure, a write at edge w is seen by searches accepted at edge w or later, and not by a search accepted at edge w-1.
- R10: Only the hashed row is examined. A key stored in any other row is not found, and a write with `w_live`=0 removes an entry.
- R11: After reset `r_valid`=0, `s_ready`=1 and every row slot and overflow entry is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Search key valid |
| s_ready | output | 1 | Pipeline can accept a key |
| s_key | input | KEY_W | Search key |
| r_valid | output | 1 | Result valid |
| r_ready | input | 1 | Consumer takes the result |
| r_hit | output | 1 | Key was found |
| r_ovf | output | 1 | Hit came from the overflow store |
| r_slot | output | SEL_W | Winning slot or overflow entry number |
| r_data | output | DATA_W | Data of the winning entry |
| w_en | input | 1 | Write strobe |
| w_ovf | input | 1 | 1: write an overflow entry, 0: write a row slot |
| w_row | input | ROW_BITS | Row number for a row write |
| w_slot | input | SEL_W | Slot number or overflow entry number |
| w_live | input | 1 | Live flag written with the entry |
| w_key | input | KEY_W | Key written |
| w_data | input | DATA_W | Data written |

## Verification
The bench builds the block with its defaults: 64 rows, 8 slots, a 16-bit key, 8-bit data and 4 overflow entries. With these values a hand-folded key can be placed at a known row. The top slot (7), the last row (63) and the last overflow entry (3) can all be reached. Duplicate keys inside one row test the slot priority. A key found in both a row and the overflow store tests the row-first rule.

// File: rtl/lookup_pkg.sv
package lookup_pkg;
  localparam int unsigned LK_ROW_BITS = 6;
  localparam int unsigned LK_SLOTS    = 8;
  localparam int unsigned LK_KEY_W    = 16;
  localparam int unsigned LK_DATA_W   = 8;
  localparam int unsigned LK_OVF_N    = 4;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/row_index_gen.sv
module row_index_gen #(
  parameter int unsigned KEY_W    = 16,
  parameter int unsigned ROW_BITS = 6
) (
  input  logic [KEY_W-1:0]    key,
  output logic [ROW_BITS-1:0] row
);
  localparam int unsigned CHUNKS = (KEY_W + ROW_BITS - 1) / ROW_BITS;
  localparam int unsigned PAD_W  = CHUNKS * ROW_BITS;

  logic [PAD_W-1:0] padded;
  assign padded = PAD_W'(key);

  always_comb begin
    row = '0;
    for (int c = 0; c < int'(CHUNKS); c++) begin
      row = row ^ padded[c*ROW_BITS +: ROW_BITS];
    end
  end
endmodule

// File: rtl/slot_matcher.sv
module slot_matcher #(
  parameter int unsigned SLOTS  = 8,
  parameter int unsigned KEY_W  = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned IDX_W  = 3
) (
  input  logic [KEY_W-1:0]              key,
  input  logic [SLOTS-1:0]              live,
  input  logic [SLOTS-1:0][KEY_W-1:0]   keys,
  input  logic [SLOTS-1:0][DATA_W-1:0]  data,
  output logic                          hit,
  output logic [IDX_W-1:0]              idx,
  output logic [DATA_W-1:0]             dout
);
  logic [SLOTS-1:0] eq;

  for (genvar s = 0; s < SLOTS; s++) begin : g_cmp
    assign eq[s] = live[s] && (keys[s] == key);
  end

  // lowest slot wins: scan downward so the last assignment is the lowest index
  always_comb begin
    hit  = 1'b0;
    idx  = '0;
    dout = '0;
    for (int s = int'(SLOTS) - 1; s >= 0; s--) begin
      if (eq[s]) begin
        hit  = 1'b1;
        idx  = IDX_W'(s);
        dout = data[s];
      end
    end
  end

  // R2: a reported hit names a live entry holding exactly the search key
  always_comb begin
    if (hit) begin
      p_hit_is_real_r2: assert (live[idx] && (keys[idx] == key) && (dout == data[idx]));
    end
  end
endmodule

// File: rtl/row_store.sv
module row_store #(
  parameter int unsigned ROW_BITS = 6,
  parameter int unsigned SLOTS    = 8,
  parameter int unsigned KEY_W    = 16,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned SLOT_W   = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          rd_en,
  input  logic [ROW_BITS-1:0]           rd_row,
  output logic [SLOTS-1:0]              rd_live,
  output logic [SLOTS-1:0][KEY_W-1:0]   rd_keys,
  output logic [SLOTS-1:0][DATA_W-1:0]  rd_data,
  input  logic                          wr_en,
  input  logic [ROW_BITS-1:0]           wr_row,
  input  logic [SLOT_W-1:0]             wr_slot,
  input  logic                          wr_live,
  input  logic [KEY_W-1:0]              wr_key,
  input  logic [DATA_W-1:0]             wr_data
);
  localparam int unsigned ROWS = 1 << ROW_BITS;

  logic [SLOTS-1:0]             live_q [ROWS];
  logic [SLOTS-1:0][KEY_W-1:0]  key_q  [ROWS];
  logic [SLOTS-1:0][DATA_W-1:0] data_q [ROWS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < int'(ROWS); r++) live_q[r] <= '0;
    end else if (wr_en) begin
      live_q[wr_row][wr_slot] <= wr_live;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      key_q[wr_row][wr_slot]  <= wr_key;
      data_q[wr_row][wr_slot] <= wr_data;
    end
  end

  // one synchronous row read per lookup; a same-edge write is seen next time
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_live <= '0;
      rd_keys <= '0;
      rd_data <= '0;
    end else if (rd_en) begin
      rd_live <= live_q[rd_row];
      rd_keys <= key_q[rd_row];
      rd_data <= data_q[rd_row];
    end
  end
endmodule

// File: rtl/ovf_cam.sv
module ovf_cam #(
  parameter int unsigned ENTRIES = 4,
  parameter int unsigned KEY_W   = 16,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned IDX_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [KEY_W-1:0]  key,
  output logic              hit_q,
  output logic [IDX_W-1:0]  idx_q,
  output logic [DATA_W-1:0] data_q,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_live,
  input  logic [KEY_W-1:0]  wr_key,
  input  logic [DATA_W-1:0] wr_data
);
  logic [ENTRIES-1:0]             live;
  logic [ENTRIES-1:0][KEY_W-1:0]  keys;
  logic [ENTRIES-1:0][DATA_W-1:0] vals;
  logic                           hit_c;
  logic [IDX_W-1:0]               idx_c;
  logic [DATA_W-1:0]              data_c;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live <= '0;
      keys <= '0;
      vals <= '0;
    end else if (wr_en) begin
      live[wr_idx] <= wr_live;
      keys[wr_idx] <= wr_key;
      vals[wr_idx] <= wr_data;
    end
  end

  slot_matcher #(
    .SLOTS(ENTRIES), .KEY_W(KEY_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) u_match (
    .key(key), .live(live), .keys(keys), .data(vals),
    .hit(hit_c), .idx(idx_c), .dout(data_c)
  );

  // probe result lands in the same stage as the row read
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_q  <= 1'b0;
      idx_q  <= '0;
      data_q <= '0;
    end else if (en) begin
      hit_q  <= hit_c;
      idx_q  <= idx_c;
      data_q <= data_c;
    end
  end
endmodule

// File: rtl/hash_row_lookup.sv
module hash_row_lookup
  import lookup_pkg::*;
#(
  parameter int unsigned ROW_BITS = LK_ROW_BITS,
  parameter int unsigned SLOTS    = LK_SLOTS,
  parameter int unsigned KEY_W    = LK_KEY_W,
  parameter int unsigned DATA_W   = LK_DATA_W,
  parameter int unsigned OVF_N    = LK_OVF_N,
  localparam int unsigned SLOT_W  = idx_width(SLOTS),
  localparam int unsigned OVF_W   = idx_width(OVF_N),
  localparam int unsigned SEL_W   = max_u(SLOT_W, OVF_W)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [KEY_W-1:0]    s_key,
  output logic                r_valid,
  input  logic                r_ready,
  output logic                r_hit,
  output logic                r_ovf,
  output logic [SEL_W-1:0]    r_slot,
  output logic [DATA_W-1:0]   r_data,
  input  logic                w_en,
  input  logic                w_ovf,
  input  logic [ROW_BITS-1:0] w_row,
  input  logic [SEL_W-1:0]    w_slot,
  input  logic                w_live,
  input  logic [KEY_W-1:0]    w_key,
  input  logic [DATA_W-1:0]   w_data
);
  logic adv;
  assign adv     = !r_valid || r_ready;
  assign s_ready = adv;

  // stage 1: index generation
  logic [ROW_BITS-1:0] idx_c;
  logic                v1;
  logic [KEY_W-1:0]    k1;
  logic [ROW_BITS-1:0] idx1;

  row_index_gen #(.KEY_W(KEY_W), .ROW_BITS(ROW_BITS)) u_idx (
    .key(s_key), .row(idx_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1   <= 1'b0;
      k1   <= '0;
      idx1 <= '0;
    end else if (adv) begin
      v1   <= s_valid;
      k1   <= s_key;
      idx1 <= idx_c;
    end
  end

  // stage 2: row read and overflow probe
  logic                         v2;
  logic [KEY_W-1:0]             k2;
  logic [SLOTS-1:0]             row_live;
  logic [SLOTS-1:0][KEY_W-1:0]  row_keys;
  logic [SLOTS-1:0][DATA_W-1:0] row_data;
  logic                         ovf_hit2;
  logic [OVF_W-1:0]             ovf_idx2;
  logic [DATA_W-1:0]            ovf_data2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v2 <= 1'b0;
      k2 <= '0;
    end else if (adv) begin
      v2 <= v1;
      k2 <= k1;
    end
  end

  row_store #(
    .ROW_BITS(ROW_BITS), .SLOTS(SLOTS), .KEY_W(KEY_W), .DATA_W(DATA_W), .SLOT_W(SLOT_W)
  ) u_rows (
    .clk(clk), .rst_n(rst_n),
    .rd_en(adv), .rd_row(idx1),
    .rd_live(row_live), .rd_keys(row_keys), .rd_data(row_data),
    .wr_en(w_en && !w_ovf), .wr_row(w_row), .wr_slot(w_slot[SLOT_W-1:0]),
    .wr_live(w_live), .wr_key(w_key), .wr_data(w_data)
  );

  ovf_cam #(
    .ENTRIES(OVF_N), .KEY_W(KEY_W), .DATA_W(DATA_W), .IDX_W(OVF_W)
  ) u_ovf (
    .clk(clk), .rst_n(rst_n), .en(adv), .key(k1),
    .hit_q(ovf_hit2), .idx_q(ovf_idx2), .data_q(ovf_data2),
    .wr_en(w_en && w_ovf), .wr_idx(w_slot[OVF_W-1:0]),
    .wr_live(w_live), .wr_key(w_key), .wr_data(w_data)
  );

  // stage 3: parallel slot match
  logic              row_hit_c;
  logic [SLOT_W-1:0] row_slot_c;
  logic [DATA_W-1:0] row_dout_c;

  slot_matcher #(
    .SLOTS(SLOTS), .KEY_W(KEY_W), .DATA_W(DATA_W), .IDX_W(SLOT_W)
  ) u_match (
    .key(k2), .live(row_live), .keys(row_keys), .data(row_data),
    .hit(row_hit_c), .idx(row_slot_c), .dout(row_dout_c)
  );

  logic              v3;
  logic              row_hit3;
  logic [SLOT_W-1:0] row_slot3;
  logic [DATA_W-1:0] row_data3;
  logic              ovf_hit3;
  logic [OVF_W-1:0]  ovf_idx3;
  logic [DATA_W-1:0] ovf_data3;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v3        <= 1'b0;
      row_hit3  <= 1'b0;
      row_slot3 <= '0;
      row_data3 <= '0;
      ovf_hit3  <= 1'b0;
      ovf_idx3  <= '0;
      ovf_data3 <= '0;
    end else if (adv) begin
      v3        <= v2;
      row_hit3  <= row_hit_c;
      row_slot3 <= row_slot_c;
      row_data3 <= row_dout_c;
      ovf_hit3  <= ovf_hit2;
      ovf_idx3  <= ovf_idx2;
      ovf_data3 <= ovf_data2;
    end
  end

  // stage 4: result forwarding, row before overflow
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_valid <= 1'b0;
      r_hit   <= 1'b0;
      r_ovf   <= 1'b0;
      r_slot  <= '0;
      r_data  <= '0;
    end else if (adv) begin
      r_valid <= v3;
      if (row_hit3) begin
        r_hit  <= 1'b1;
        r_ovf  <= 1'b0;
        r_slot <= SEL_W'(row_slot3);
        r_data <= row_data3;
      end else if (ovf_hit3) begin
        r_hit  <= 1'b1;
        r_ovf  <= 1'b1;
        r_slot <= SEL_W'(ovf_idx3);
        r_data <= ovf_data3;
      end else begin
        r_hit  <= 1'b0;
        r_ovf  <= 1'b0;
        r_slot <= '0;
        r_data <= '0;
      end
    end
  end

  // R8: a held result does not move
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (r_valid && !r_ready) |=> (r_valid && $stable(r_hit) && $stable(r_ovf)
                               && $stable(r_slot) && $stable(r_data)));

  // R7: an accepted key occupies stage 1 on the next cycle
  p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> v1);

  // R7: with an empty stage 3, a consumed result leaves nothing behind
  p_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (r_valid && r_ready && !v3) |=> !r_valid);

  // R6: a miss carries zeros
  p_miss_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (r_valid && !r_hit) |-> (!r_ovf && r_slot == '0 && r_data == '0));
endmodule

// File: tb/sim_hash_row_lookup.sv
module sim_hash_row_lookup;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [15:0] s_key = '0;
  logic        r_valid;
  logic        r_ready = 1'b1;
  logic        r_hit;
  logic        r_ovf;
  logic [2:0]  r_slot;
  logic [7:0]  r_data;
  logic        w_en = 1'b0;
  logic        w_ovf = 1'b0;
  logic [5:0]  w_row = '0;
  logic [2:0]  w_slot = '0;
  logic        w_live = 1'b0;
  logic [15:0] w_key = '0;
  logic [7:0]  w_data = '0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hash_row_lookup u0 (
    .clk(clk), .rst_n(rst_n),
    .s_valid(s_valid), .s_ready(s_ready), .s_key(s_key),
    .r_valid(r_valid), .r_ready(r_ready), .r_hit(r_hit), .r_ovf(r_ovf),
    .r_slot(r_slot), .r_data(r_data),
    .w_en(w_en), .w_ovf(w_ovf), .w_row(w_row), .w_slot(w_slot),
    .w_live(w_live), .w_key(w_key), .w_data(w_data)
  );

  // {key, hit, ovf, slot, data}
  localparam int NV = 8;
  localparam logic [28:0] VEC [NV] = '{
    {16'h1234, 1'b1, 1'b0, 3'd2, 8'hA1},  // R1 R5: hand-folded row 61, also in overflow
    {16'h0005, 1'b1, 1'b0, 3'd0, 8'h11},  // R3: duplicates in slots 0 and 3
    {16'h0007, 1'b1, 1'b0, 3'd4, 8'h44},  // R3: duplicates in slots 4 and 6
    {16'h0009, 1'b1, 1'b1, 3'd2, 8'h99},  // R4
    {16'h000B, 1'b0, 1'b0, 3'd0, 8'h00},  // R10: stored in row 10, hashes to 11
    {16'h0020, 1'b0, 1'b0, 3'd0, 8'h00},  // R6
    {16'h003F, 1'b1, 1'b0, 3'd7, 8'h77},  // R2: row 63, slot 7
    {16'hFFFF, 1'b1, 1'b1, 3'd3, 8'h5A}   // R4: last overflow entry
  };

  function automatic logic [13:0] res();
    return {r_valid, r_hit, r_ovf, r_slot, r_data};
  endfunction

  task automatic check(input string tag, input logic [13:0] act, input logic [13:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic ovf, input logic [5:0] row, input logic [2:0] slot,
                    input logic live, input logic [15:0] key, input logic [7:0] data);
    @(negedge clk);
    w_en = 1'b1; w_ovf = ovf; w_row = row; w_slot = slot;
    w_live = live; w_key = key; w_data = data;
    @(negedge clk);
    w_en = 1'b0;
  endtask

  task automatic search(input logic [15:0] key);
    @(negedge clk);
    s_valid = 1'b1; s_key = key;
    @(negedge clk);
    s_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 r_valid after reset", {13'b0, r_valid}, 14'd0);
    check("R11 s_ready after reset", {13'b0, s_ready}, 14'd1);
    search(16'h0000);
    check("R11 empty table misses", res(), {1'b1, 1'b0, 1'b0, 3'd0, 8'h00});

    wr(1'b0, 6'd61, 3'd2, 1'b1, 16'h1234, 8'hA1);
    wr(1'b1, 6'd0,  3'd1, 1'b1, 16'h1234, 8'hEE);
    wr(1'b0, 6'd5,  3'd0, 1'b1, 16'h0005, 8'h11);
    wr(1'b0, 6'd5,  3'd3, 1'b1, 16'h0005, 8'h33);
    wr(1'b0, 6'd7,  3'd6, 1'b1, 16'h0007, 8'h66);
    wr(1'b0, 6'd7,  3'd4, 1'b1, 16'h0007, 8'h44);
    wr(1'b1, 6'd0,  3'd2, 1'b1, 16'h0009, 8'h99);
    wr(1'b0, 6'd10, 3'd0, 1'b1, 16'h000B, 8'hBB);
    wr(1'b0, 6'd63, 3'd7, 1'b1, 16'h003F, 8'h77);
    wr(1'b1, 6'd0,  3'd3, 1'b1, 16'hFFFF, 8'h5A);

    for (int i = 0; i < NV; i++) begin
      search(VEC[i][28:13]);
      check($sformatf("R1-R6 vector %0d", i), res(), {1'b1, VEC[i][12:0]});
    end

    // R10: clearing slot 0 exposes the slot 3 duplicate
    wr(1'b0, 6'd5, 3'd0, 1'b0, 16'h0005, 8'h11);
    search(16'h0005);
    check("R10 cleared entry gone", res(), {1'b1, 1'b1, 1'b0, 3'd3, 8'h33});

    // R9: search at edge w-1 misses, write and search at edge w hits
    @(negedge clk);
    s_valid = 1'b1; s_key = 16'h0021;
    @(negedge clk);
    w_en = 1'b1; w_ovf = 1'b0; w_row = 6'd33; w_slot = 3'd1;
    w_live = 1'b1; w_key = 16'h0021; w_data = 8'hC3;
    @(negedge clk);
    s_valid = 1'b0; w_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R9 search before write", res(), {1'b1, 1'b0, 1'b0, 3'd0, 8'h00});
    @(negedge clk);
    check("R9 search with write", res(), {1'b1, 1'b1, 1'b0, 3'd1, 8'hC3});
    @(negedge clk);

    // R7: four back-to-back keys, results four cycles after each drive
    for (int j = 0; j < 8; j++) begin
      @(negedge clk);
      if (j >= 4) begin
        case (j)
          4: check("R7 stream 0", res(), {1'b1, 1'b1, 1'b0, 3'd2, 8'hA1});
          5: check("R7 stream 1", res(), {1'b1, 1'b0, 1'b0, 3'd0, 8'h00});
          6: check("R7 stream 2", res(), {1'b1, 1'b1, 1'b1, 3'd2, 8'h99});
          default: check("R7 stream 3", res(), {1'b1, 1'b1, 1'b0, 3'd7, 8'h77});
        endcase
      end
      if (j < 4) begin
        s_valid = 1'b1;
        case (j)
          0: s_key = 16'h1234;
          1: s_key = 16'h0020;
          2: s_key = 16'h0009;
          default: s_key = 16'h003F;
        endcase
      end else begin
        s_valid = 1'b0;
      end
    end
    @(negedge clk);
    check("R7 stream drained", {13'b0, r_valid}, 14'd0);

    // R8: back-pressure holds the first result and stalls input
    @(negedge clk);
    r_ready = 1'b0; s_valid = 1'b1; s_key = 16'h1234;
    @(negedge clk);
    s_key = 16'h0009;
    @(negedge clk);
    s_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R8 first result", res(), {1'b1, 1'b1, 1'b0, 3'd2, 8'hA1});
    check("R8 s_ready low when held", {13'b0, s_ready}, 14'd0);
    @(negedge clk);
    @(negedge clk);
    check("R8 result held", res(), {1'b1, 1'b1, 1'b0, 3'd2, 8'hA1});
    r_ready = 1'b1;
    @(negedge clk);
    check("R8 second result after release", res(), {1'b1, 1'b1, 1'b1, 3'd2, 8'h99});
    check("R8 s_ready high when taken", {13'b0, s_ready}, 14'd1);
    @(negedge clk);
    check("R8 pipeline empty", {13'b0, r_valid}, 14'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule